// File: doc/BRIEF.md
# Array Write-Protection Decision Unit

This unit sits behind a two-wire serial memory front end and decides, one transaction at a time, whether the 256-byte array may be changed. It keeps two lock flags that cover the lower half of the array (addresses below 0x80). The sticky lock can be set but never cleared. The soft lock can be set and cleared, but only when a high-voltage qualifier is present on the lowest strap pin. A hardware protect input, when it is high, locks the whole array no matter what the flags hold.

The front end decodes each control byte and passes it to the unit: whether it is an array or a protection command, the read bit, the three select bits, and the levels of the strap pins and the high-voltage qualifier. The unit answers combinationally with an acknowledge decision. For each data byte received in an array write, it returns a per-byte write enable. A protection command is reported through its acknowledge. A flag command changes a flag only after at least one data byte and a valid stop. A blocked array write is still acknowledged, but its data is dropped.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset both flags read 0, and `ctl_ack` and `byte_we` are 0 while no strobe is active.
- R2: An array command (`cmd_prot`=0) is acknowledged exactly when `cmd_sel` equals `strap_a`, for both reads and writes.
- R3: While `hw_wp` is 1, `byte_we` is never raised for any address.
- R4: When either flag is set, data bytes aimed at addresses 0x00–0x7F get `byte_we`=0. Addresses 0x80–0xFF stay writable as long as `hw_wp` is 0.
- R5: A protection command without the qualifier (`hv_a0`=0) and with `cmd_sel` equal to `strap_a` addresses the sticky flag. It is acknowledged only while the sticky flag is 0. As a write, it sets the flag.
- R6: A protection command with `hv_a0`=1, `strap_a`[2:1]=00 and `cmd_sel`=001 addresses the soft flag. It is acknowledged only while the soft flag is 0. As a write, it sets the flag.
- R7: A write with `hv_a0`=1, `strap_a`[2:1]=01 and `cmd_sel`=011 clears the soft flag. It is acknowledged only while the sticky flag is 0. A read with this code, and any other protection code, is not acknowledged.
- R8: No command and no sequence of commands, short of reset, clears the sticky flag once it is set.
- R9: A flag write that ends with a stop while `hw_wp` is 1 is still acknowledged but changes no flag.
- R10: A flag write takes effect only when at least one data byte is followed by `stop_seen`. An abort, or a stop with no data byte, leaves both flags unchanged.
- R11: Protection queries (`cmd_rd`=1) never change a flag, and bytes in a protection command never raise `byte_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears both flags |
| cmd_valid | input | 1 | One-cycle strobe: a decoded control byte is present |
| cmd_prot | input | 1 | 1 = protection command class, 0 = array class |
| cmd_rd | input | 1 | Read/write bit of the control byte (1 = read) |
| cmd_sel | input | 3 | Three select bits of the control byte |
| strap_a | input | 3 | Levels of the three strap pins |
| hv_a0 | input | 1 | High-voltage qualifier on the lowest strap pin |
| hw_wp | input | 1 | Hardware protect; 1 locks the whole array |
| byte_valid | input | 1 | One-cycle strobe: a data byte was received |
| byte_addr | input | 8 | Target array address of that data byte |
| stop_seen | input | 1 | One-cycle strobe: valid stop condition |
| abort_seen | input | 1 | One-cycle strobe: transaction abandoned without stop |
| ctl_ack | output | 1 | Acknowledge decision, valid while `cmd_valid` is 1 |
| byte_we | output | 1 | Array write enable, valid while `byte_valid` is 1 |
| perm_flag | output | 1 | Sticky lower-half lock |
| rev_flag | output | 1 | Soft lower-half lock |

## Verification
The assertions assume a well-formed front end. At most one of the strobes `cmd_valid`, `byte_valid`, `stop_seen` and `abort_seen` is high in a cycle. Data bytes arrive only after an acknowledged write control byte. `hw_wp` holds steady from the control byte through the closing stop. The stimulus is built from tasks that each pulse exactly one strobe for one cycle. It sends bytes only after an acknowledged write and changes the pin levels only between transactions, so random sequences stay inside those assumptions.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_SET_PERM = 2'd1,
    OP_SET_REV  = 2'd2,
    OP_CLR_REV  = 2'd3
  } wp_op_e;

  typedef struct packed {
    logic   ack;
    wp_op_e op;
  } wp_dec_t;

  // Lower-half membership for an address of width aw.
  function automatic logic in_low_half(input logic [15:0] addr, input int aw);
    return (addr >> (aw - 1)) == 16'd0;
  endfunction

  // Decision for a control byte given the current flag state.
  function automatic wp_dec_t decode_cmd(
    input logic       prot,
    input logic       rd,
    input logic [2:0] sel,
    input logic [2:0] strap,
    input logic       hv,
    input logic       perm,
    input logic       rev
  );
    wp_dec_t d;
    d.ack = 1'b0;
    d.op  = OP_NONE;
    if (!prot) begin
      d.ack = (sel == strap);
    end else if (!hv) begin
      if (sel == strap) begin
        d.ack = !perm;
        d.op  = rd ? OP_NONE : OP_SET_PERM;
      end
    end else if (!strap[2] && sel == {strap[2:1], 1'b1}) begin
      if (!sel[1]) begin
        d.ack = !rev;
        d.op  = rd ? OP_NONE : OP_SET_REV;
      end else if (!rd) begin
        d.ack = !perm;
        d.op  = OP_CLR_REV;
      end
    end
    if (!d.ack) d.op = OP_NONE;
    return d;
  endfunction

endpackage

// File: rtl/wprot_decode.sv
module wprot_decode
  import wprot_pkg::*;
(
  input  logic       cmd_valid,
  input  logic       cmd_prot,
  input  logic       cmd_rd,
  input  logic [2:0] cmd_sel,
  input  logic [2:0] strap_a,
  input  logic       hv_a0,
  input  logic       perm_q,
  input  logic       rev_q,
  output logic       ack,
  output wp_op_e     op,
  output logic       arr_wr_open
);
  wp_dec_t dec;

  always_comb begin
    dec         = decode_cmd(cmd_prot, cmd_rd, cmd_sel, strap_a, hv_a0, perm_q, rev_q);
    ack         = cmd_valid & dec.ack;
    op          = cmd_valid ? dec.op : OP_NONE;
    arr_wr_open = cmd_valid & dec.ack & !cmd_prot & !cmd_rd;
  end
endmodule

// File: rtl/wprot_flags.sv
module wprot_flags
  import wprot_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cmd_valid,
  input  wp_op_e cmd_op,
  input  logic   byte_valid,
  input  logic   stop_seen,
  input  logic   abort_seen,
  input  logic   hw_wp,
  output logic   perm_q,
  output logic   rev_q
);
  wp_op_e pend_q;
  logic   got_data_q;
  logic   commit;

  assign commit = stop_seen && (pend_q != OP_NONE) && got_data_q && !hw_wp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_q     <= 1'b0;
      rev_q      <= 1'b0;
      pend_q     <= OP_NONE;
      got_data_q <= 1'b0;
    end else if (cmd_valid) begin
      pend_q     <= cmd_op;
      got_data_q <= 1'b0;
    end else if (stop_seen || abort_seen) begin
      pend_q     <= OP_NONE;
      got_data_q <= 1'b0;
      if (commit) begin
        case (pend_q)
          OP_SET_PERM: perm_q <= 1'b1;
          OP_SET_REV:  rev_q  <= 1'b1;
          OP_CLR_REV:  rev_q  <= 1'b0;
          default:     ;
        endcase
      end
    end else if (byte_valid && pend_q != OP_NONE) begin
      got_data_q <= 1'b1;
    end
  end

  assert_perm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q);
  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_seen |=> ($stable(perm_q) && $stable(rev_q)));
  assert_wp_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && hw_wp) |=> ($stable(perm_q) && $stable(rev_q)));
  assert_perm_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perm_q) |-> $past(pend_q == OP_SET_PERM));
  assert_rev_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rev_q) |-> $past(pend_q == OP_SET_REV));
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              arr_wr_open,
  input  logic              byte_valid,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              stop_seen,
  input  logic              abort_seen,
  input  logic              hw_wp,
  input  logic              lock_low,
  output logic              byte_we
);
  localparam logic [ADDR_W-1:0] HALF = ADDR_W'(1) << (ADDR_W - 1);

  logic sess_q;
  logic addr_low;

  assign addr_low = wprot_pkg::in_low_half(16'(byte_addr), ADDR_W);
  assign byte_we  = byte_valid && sess_q && !hw_wp && !(addr_low && lock_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        sess_q <= 1'b0;
    else if (cmd_valid)                sess_q <= arr_wr_open;
    else if (stop_seen || abort_seen)  sess_q <= 1'b0;
  end

  assert_wp_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_wp |-> !byte_we);
  assert_low_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we && lock_low) |-> (byte_addr >= HALF));
  assert_we_needs_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we |-> byte_valid);
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_prot,
  input  logic              cmd_rd,
  input  logic [2:0]        cmd_sel,
  input  logic [2:0]        strap_a,
  input  logic              hv_a0,
  input  logic              hw_wp,
  input  logic              byte_valid,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              stop_seen,
  input  logic              abort_seen,
  output logic              ctl_ack,
  output logic              byte_we,
  output logic              perm_flag,
  output logic              rev_flag
);
  wp_op_e op_w;
  logic   arr_wr_open;
  logic   perm_q, rev_q;
  logic   lock_low;

  assign lock_low  = perm_q | rev_q;
  assign perm_flag = perm_q;
  assign rev_flag  = rev_q;

  wprot_decode u_dec (
    .cmd_valid(cmd_valid), .cmd_prot(cmd_prot), .cmd_rd(cmd_rd), .cmd_sel(cmd_sel),
    .strap_a(strap_a), .hv_a0(hv_a0), .perm_q(perm_q), .rev_q(rev_q),
    .ack(ctl_ack), .op(op_w), .arr_wr_open(arr_wr_open)
  );

  wprot_flags u_flags (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op_w),
    .byte_valid(byte_valid), .stop_seen(stop_seen), .abort_seen(abort_seen),
    .hw_wp(hw_wp), .perm_q(perm_q), .rev_q(rev_q)
  );

  wprot_gate #(.ADDR_W(ADDR_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .arr_wr_open(arr_wr_open),
    .byte_valid(byte_valid), .byte_addr(byte_addr), .stop_seen(stop_seen),
    .abort_seen(abort_seen), .hw_wp(hw_wp), .lock_low(lock_low), .byte_we(byte_we)
  );

  assert_sticky_refuses_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_prot && !hv_a0 && perm_q) |-> !ctl_ack);
  assert_array_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_prot && cmd_sel != strap_a) |-> !ctl_ack);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !ctl_ack);
endmodule

// File: tb/wprot_ctrl_bench.sv
`timescale 1ns/1ps
module wprot_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_prot = 0, cmd_rd = 0;
  logic [2:0] cmd_sel = 0, strap_a = 0;
  logic hv_a0 = 0, hw_wp = 0, byte_valid = 0, stop_seen = 0, abort_seen = 0;
  logic [7:0] byte_addr = 0;
  logic ctl_ack, byte_we, perm_flag, rev_flag;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_perm = 0, m_rev = 0;

  always #10 clk = ~clk;

  wprot_ctrl u_wprot_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_prot(cmd_prot), .cmd_rd(cmd_rd),
    .cmd_sel(cmd_sel), .strap_a(strap_a), .hv_a0(hv_a0), .hw_wp(hw_wp),
    .byte_valid(byte_valid), .byte_addr(byte_addr), .stop_seen(stop_seen),
    .abort_seen(abort_seen), .ctl_ack(ctl_ack), .byte_we(byte_we),
    .perm_flag(perm_flag), .rev_flag(rev_flag)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Expected acknowledge, written from the requirement text.
  function automatic bit m_ack(bit prot, bit rd, bit [2:0] sel, bit [2:0] st, bit hv, bit p, bit r);
    if (!prot) return sel == st;                   // R2
    if (!hv) return (sel == st) && !p;             // R5
    if (st[2:1] == 2'b00 && sel == 3'b001) return !r;            // R6
    if (st[2:1] == 2'b01 && sel == 3'b011) return !rd && !p;     // R7
    return 0;
  endfunction

  function automatic bit m_we(bit wp, bit p, bit r, bit [7:0] a);
    if (wp) return 0;                              // R3
    return a >= 8'h80 || !(p || r);                // R4
  endfunction

  task automatic send_cmd(input bit prot, input bit rd, input bit [2:0] sel, output bit got);
    @(posedge clk); #1;
    cmd_valid = 1; cmd_prot = prot; cmd_rd = rd; cmd_sel = sel;
    @(negedge clk); got = ctl_ack;
    @(posedge clk); #1; cmd_valid = 0;
  endtask

  task automatic send_byte(input bit [7:0] a, output bit we);
    @(posedge clk); #1; byte_valid = 1; byte_addr = a;
    @(negedge clk); we = byte_we;
    @(posedge clk); #1; byte_valid = 0;
  endtask

  task automatic end_tx(input bit is_abort);
    @(posedge clk); #1;
    if (is_abort) abort_seen = 1; else stop_seen = 1;
    @(posedge clk); #1; abort_seen = 0; stop_seen = 0;
  endtask

  task automatic check_flags(input string req);
    @(negedge clk);
    check(req, perm_flag, m_perm);
    check(req, rev_flag, m_rev);
  endtask

  // Full flag command: control byte, optional data byte, then stop or abort.
  task automatic flag_cmd(input bit [2:0] st, input bit hv, input bit [2:0] sel,
                          input bit data, input bit is_abort, output bit got);
    bit we;
    strap_a = st; hv_a0 = hv;
    send_cmd(1, 0, sel, got);
    if (data) send_byte(8'h00, we);
    end_tx(is_abort);
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (2) @(posedge clk); #1; rst_n = 1;
    m_perm = 0; m_rev = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    bit got, we;
    int unused_seed;
    unused_seed = $urandom(32'd9137);
    repeat (2) @(posedge clk); #1;
    @(negedge clk);
    check("R1 reset perm", perm_flag, 0);
    check("R1 reset rev", rev_flag, 0);
    check("R1 reset ack", ctl_ack, 0);
    check("R1 reset we", byte_we, 0);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    check("R1 after release perm", perm_flag, 0);

    // R2 array select match / mismatch
    strap_a = 3'b101;
    send_cmd(0, 1, 3'b101, got); check("R2 read match", got, 1); end_tx(0);
    send_cmd(0, 0, 3'b100, got); check("R2 write mismatch", got, 0); end_tx(0);

    // R4 free array, R3 hardware lock
    send_cmd(0, 0, 3'b101, got); check("R2 write match", got, 1);
    send_byte(8'h10, we); check("R4 low free", we, 1);
    send_byte(8'hF0, we); check("R4 high free", we, 1);
    end_tx(0);
    hw_wp = 1;
    send_cmd(0, 0, 3'b101, got); check("R3 ack under wp", got, 1);
    send_byte(8'hC0, we); check("R3 high blocked", we, 0);
    send_byte(8'h05, we); check("R3 low blocked", we, 0);
    end_tx(0); hw_wp = 0;

    // R6 soft lock set
    flag_cmd(3'b000, 1, 3'b001, 1, 0, got); check("R6 set ack", got, 1);
    m_rev = 1; check_flags("R6 set effect");
    strap_a = 3'b000; hv_a0 = 0;
    send_cmd(0, 0, 3'b000, got);
    send_byte(8'h7F, we); check("R4 low locked", we, 0);
    send_byte(8'h80, we); check("R4 high open", we, 1);
    end_tx(0);
    hv_a0 = 1;
    send_cmd(1, 1, 3'b001, got); check("R6 query when set", got, 0); end_tx(0);
    flag_cmd(3'b000, 1, 3'b001, 1, 0, got); check("R6 set twice", got, 0);

    // R9 hardware lock during clear
    hw_wp = 1;
    flag_cmd(3'b010, 1, 3'b011, 1, 0, got); check("R9 clear ack", got, 1);
    hw_wp = 0; check_flags("R9 no effect");
    // R10 abort and missing data byte
    flag_cmd(3'b010, 1, 3'b011, 1, 1, got); check_flags("R10 abort");
    flag_cmd(3'b010, 1, 3'b011, 0, 0, got); check_flags("R10 no data");
    // R7 clear
    flag_cmd(3'b010, 1, 3'b011, 1, 0, got); check("R7 clear ack", got, 1);
    m_rev = 0; check_flags("R7 clear effect");
    strap_a = 3'b010;
    send_cmd(1, 1, 3'b011, got); check("R7 read of clear code", got, 0); end_tx(0);
    strap_a = 3'b110;
    send_cmd(1, 0, 3'b111, got); check("R7 strap A2 high", got, 0); end_tx(0);

    // R11 query keeps state, R5 sticky lock
    strap_a = 3'b011; hv_a0 = 0;
    send_cmd(1, 1, 3'b011, got); check("R11 query ack", got, 1);
    send_byte(8'h01, we); check("R11 no we in prot", we, 0);
    end_tx(0); check_flags("R11 query no effect");
    flag_cmd(3'b011, 0, 3'b011, 1, 0, got); check("R5 set ack", got, 1);
    m_perm = 1; check_flags("R5 set effect");
    hv_a0 = 0;
    send_cmd(1, 1, 3'b011, got); check("R5 query when set", got, 0); end_tx(0);
    flag_cmd(3'b010, 1, 3'b011, 1, 0, got); check("R7 clear refused", got, 0);
    check_flags("R8 sticky stays");

    // Random phase against the model.
    for (int it = 0; it < 400; it++) begin
      bit prot, rd, hv, wp, ab, exp_a;
      bit [2:0] st, sel;
      int nb;
      if (it % 60 == 0) begin do_reset(); check_flags("R1 random reset"); end
      st = 3'($urandom); hv = ($urandom % 3) == 0; wp = ($urandom % 5) == 0;
      if (hv && ($urandom % 2)) st[2] = 0;
      prot = $urandom % 2; rd = ($urandom % 4) == 0;
      case ($urandom % 3)
        0: sel = st;
        1: sel = {st[2:1], 1'b1};
        default: sel = 3'($urandom);
      endcase
      strap_a = st; hv_a0 = hv; hw_wp = wp;
      exp_a = m_ack(prot, rd, sel, st, hv, m_perm, m_rev);
      send_cmd(prot, rd, sel, got);
      check(prot ? "R5 R6 R7 random ack" : "R2 random ack", got, exp_a);
      nb = 0;
      if (got && !rd) begin
        nb = $urandom % 3;
        for (int k = 0; k < nb; k++) begin
          bit [7:0] a;
          a = 8'($urandom);
          send_byte(a, we);
          check("R3 R4 R11 random we", we, prot ? 1'b0 : m_we(wp, m_perm, m_rev, a));
        end
      end
      ab = ($urandom % 4) == 0;
      end_tx(ab);
      if (prot && exp_a && !rd && nb > 0 && !ab && !wp) begin
        if (!hv) m_perm = 1;
        else if (!sel[1]) m_rev = 1;
        else m_rev = 0;
      end
      check_flags("R8 R9 R10 random flags");
      hw_wp = 0;
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule